// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Sequencer

This block sits between a synchronous instruction memory read port and a decode stage. It reads the first word of an instruction and sorts it into one of twelve format groups using the low ten bits. From the format it works out how many words the instruction occupies, which is one, two or three. It then issues the extra reads and hands the assembled instruction to the decode stage over a valid/ready handshake. The handoff carries the instruction words, the format code, the length, the merged immediate operand and two flags.

One word value acts as a double-byte-data prefix. An immediate-operand instruction that directly follows that prefix takes one extra word. Its 16-bit constant is then built from the low bytes of its two data words. The prefix status is also reported with every instruction, so indirect-mode decode can tell prefixed accesses from plain ones. A first word with any bit above bit 9 set is not decoded: it is trapped and presented as an invalid one-word instruction.

The externally visible program counter stays on the first word of the instruction until the decode stage accepts it.

Top module: `insn_fetch_seq`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0, `pc` equals the `RESET_PC` parameter, `out_prefixed` is 0, and the first read is issued at `RESET_PC`.
- R2: A valid first word is classified from bits 9:0. Format codes are implied-A 0, implied-B 1, jump 2, register 1-op 3, status read 4, NOP/SIN 5, rotate 6, register 2-op 7, branch 8, direct 9, indirect 10, immediate 11. For bits 9:6 = 0 and bits 5:3 = 0: values 0..3 are implied-A, 4 is jump, 5..7 are implied-B. For bits 9:6 = 0 and bits 5:3 = 6: bit 2 low is status read and bit 2 high is NOP/SIN. Any other bits 9:6 = 0 word is register 1-op. Bits 9:6 = 1 is rotate. Bits 9:6 from 2 to 7 is register 2-op. Bits 9:6 = 8 is branch. For bits 9:6 of 9 or more, bits 5:3 = 0 gives direct, 7 gives immediate, and any other value gives indirect.
- R3: The length in words is 3 for jump and 2 for branch, direct and immediate. It is 1 for every other format.
- R4: One read is issued per word of the instruction, at consecutive addresses starting at `pc`. Read data arrives one cycle after the read. Word slots beyond the length are presented as 0.
- R5: `pc` holds the first-word address until the instruction is accepted, then advances by the length.
- R6: While `out_valid` is high and `out_ready` low, the outputs hold still and no read is issued. No new read starts until the instruction is accepted.
- R7: A first word with any of bits 15:10 set is presented with `out_invalid` = 1, length 1, format 0 and no extra reads.
- R8: The prefix flag is set when a valid one-word instruction equal to 0x0001 is accepted. It is cleared when any other instruction is accepted, an invalid one included. `out_prefixed` shows the flag in force for the presented instruction.
- R9: An immediate instruction with the flag set has length 3, and `out_imm` = {word2[7:0], word1[7:0]}. Without the flag it has length 2 and `out_imm` = word1. `out_imm` is 0 for all other formats.
- R10: An indirect instruction reports `out_prefixed` as set when it follows the prefix, and its length stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_rd_en | output | 1 | Read strobe to instruction memory |
| mem_addr | output | AW | Read address |
| mem_rdata | input | DW | Read data, one cycle after the strobe |
| pc | output | AW | Address of the first word of the current instruction |
| out_valid | output | 1 | Assembled instruction available |
| out_ready | input | 1 | Decode stage accepts the instruction |
| out_fmt | output | 4 | Format code |
| out_len | output | 2 | Length in words |
| out_word0 | output | DW | First word |
| out_word1 | output | DW | Second word or 0 |
| out_word2 | output | DW | Third word or 0 |
| out_imm | output | DW | Merged immediate operand |
| out_prefixed | output | 1 | Prefix flag in force for this instruction |
| out_invalid | output | 1 | First word had upper bits set |

## Verification
The assertions watch the handshake every cycle. They check that a stalled instruction holds still and that no read overlaps a presentation. They check that `pc` only moves on acceptance and then by exactly the presented length, and that every read address lies within three words of `pc`. They also check that trapped words are always one word long. Only the bench's scenarios can show that each format's boundary values classify correctly. The same holds for the read count per instruction matching its length, and for the prefix flag being set and cleared across instruction sequences, including a trapped word after a prefix. The merged immediate's byte placement is likewise shown only by the bench.

// File: rtl/insn_fetch_pkg.sv
package insn_fetch_pkg;

    localparam int OP_BITS = 10;

    typedef enum logic [3:0] {
        FMT_IMPL_A   = 4'd0,
        FMT_IMPL_B   = 4'd1,
        FMT_JUMP     = 4'd2,
        FMT_REG1     = 4'd3,
        FMT_STATUS   = 4'd4,
        FMT_NOPSIN   = 4'd5,
        FMT_ROTATE   = 4'd6,
        FMT_REG2     = 4'd7,
        FMT_BRANCH   = 4'd8,
        FMT_DIRECT   = 4'd9,
        FMT_INDIRECT = 4'd10,
        FMT_IMMED    = 4'd11
    } fmt_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH1,
        ST_FETCH2,
        ST_FETCH3,
        ST_PRESENT
    } fetch_st_e;

    // words occupied by a format when no prefix is in force
    function automatic logic [1:0] base_len(fmt_e f);
        case (f)
            FMT_JUMP:                          return 2'd3;
            FMT_BRANCH, FMT_DIRECT, FMT_IMMED: return 2'd2;
            default:                           return 2'd1;
        endcase
    endfunction

endpackage

// File: rtl/insn_fmt_classify.sv
module insn_fmt_classify
    import insn_fetch_pkg::*;
(
    input  logic [OP_BITS-1:0] op,
    output fmt_e               fmt
);
    logic [3:0] grp;
    logic [2:0] mode;
    logic [2:0] low;

    assign grp  = op[9:6];
    assign mode = op[5:3];
    assign low  = op[2:0];

    always_comb begin
        if (grp == 4'd0) begin
            if (mode == 3'd0) begin
                if (low <= 3'd3)      fmt = FMT_IMPL_A;
                else if (low == 3'd4) fmt = FMT_JUMP;
                else                  fmt = FMT_IMPL_B;
            end else if (mode == 3'd6) begin
                fmt = low[2] ? FMT_NOPSIN : FMT_STATUS;
            end else begin
                fmt = FMT_REG1;
            end
        end else if (grp == 4'd1) begin
            fmt = FMT_ROTATE;
        end else if (grp < 4'd8) begin
            fmt = FMT_REG2;
        end else if (grp == 4'd8) begin
            fmt = FMT_BRANCH;
        end else if (mode == 3'd0) begin
            fmt = FMT_DIRECT;
        end else if (mode == 3'd7) begin
            fmt = FMT_IMMED;
        end else begin
            fmt = FMT_INDIRECT;
        end
    end
endmodule

// File: rtl/insn_imm_merge.sv
module insn_imm_merge
    import insn_fetch_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [3:0]    fmt,
    input  logic          bad,
    input  logic          pfx,
    input  logic [DW-1:0] w1,
    input  logic [DW-1:0] w2,
    output logic [DW-1:0] imm
);
    localparam int HALF = DW / 2;

    always_comb begin
        if (bad || fmt != FMT_IMMED) imm = '0;
        else if (pfx)                imm = {w2[HALF-1:0], w1[HALF-1:0]};
        else                         imm = w1;
    end
endmodule

// File: rtl/insn_fetch_seq.sv
module insn_fetch_seq
    import insn_fetch_pkg::*;
#(
    parameter int            AW       = 16,
    parameter int            DW       = 16,
    parameter logic [AW-1:0] RESET_PC = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          mem_rd_en,
    output logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] pc,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [3:0]    out_fmt,
    output logic [1:0]    out_len,
    output logic [DW-1:0] out_word0,
    output logic [DW-1:0] out_word1,
    output logic [DW-1:0] out_word2,
    output logic [DW-1:0] out_imm,
    output logic          out_prefixed,
    output logic          out_invalid
);
    localparam logic [DW-1:0] PREFIX_WORD = DW'(1);

    typedef struct packed {
        fetch_st_e     st;
        logic [AW-1:0] pc;
        logic [DW-1:0] w0;
        logic [DW-1:0] w1;
        logic [DW-1:0] w2;
        logic [3:0]    fmt;
        logic [1:0]    len;
        logic          bad;
        logic          pfx;
    } fetch_regs_t;

    fetch_regs_t q, d;
    fmt_e        fmt_now;
    logic        hi_set;
    logic [1:0]  len_now;
    logic        accept;

    insn_fmt_classify u_cls (
        .op  (mem_rdata[OP_BITS-1:0]),
        .fmt (fmt_now)
    );

    insn_imm_merge #(.DW(DW)) u_imm (
        .fmt (q.fmt),
        .bad (q.bad),
        .pfx (q.pfx),
        .w1  (q.w1),
        .w2  (q.w2),
        .imm (out_imm)
    );

    assign hi_set  = |mem_rdata[DW-1:OP_BITS];
    assign len_now = base_len(fmt_now) + {1'b0, (fmt_now == FMT_IMMED) && q.pfx};
    assign accept  = (q.st == ST_PRESENT) && out_ready;

    always_comb begin
        d         = q;
        mem_rd_en = 1'b0;
        mem_addr  = q.pc;
        case (q.st)
            ST_IDLE: begin
                mem_rd_en = 1'b1;
                d.st      = ST_FETCH1;
            end
            ST_FETCH1: begin
                d.w0 = mem_rdata;
                d.w1 = '0;
                d.w2 = '0;
                if (hi_set) begin
                    d.bad = 1'b1;
                    d.fmt = FMT_IMPL_A;
                    d.len = 2'd1;
                    d.st  = ST_PRESENT;
                end else begin
                    d.bad = 1'b0;
                    d.fmt = fmt_now;
                    d.len = len_now;
                    if (len_now == 2'd1) begin
                        d.st = ST_PRESENT;
                    end else begin
                        mem_rd_en = 1'b1;
                        mem_addr  = q.pc + AW'(1);
                        d.st      = ST_FETCH2;
                    end
                end
            end
            ST_FETCH2: begin
                d.w1 = mem_rdata;
                if (q.len == 2'd2) begin
                    d.st = ST_PRESENT;
                end else begin
                    mem_rd_en = 1'b1;
                    mem_addr  = q.pc + AW'(2);
                    d.st      = ST_FETCH3;
                end
            end
            ST_FETCH3: begin
                d.w2 = mem_rdata;
                d.st = ST_PRESENT;
            end
            ST_PRESENT: begin
                if (out_ready) begin
                    d.pc  = q.pc + AW'(q.len);
                    d.pfx = !q.bad && (q.len == 2'd1) && (q.w0 == PREFIX_WORD);
                    d.st  = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= '0;
            q.st  <= ST_IDLE;
            q.pc  <= RESET_PC;
            q.len <= 2'd1;
        end else begin
            q <= d;
        end
    end

    assign pc           = q.pc;
    assign out_valid    = (q.st == ST_PRESENT);
    assign out_fmt      = q.fmt;
    assign out_len      = q.len;
    assign out_word0    = q.w0;
    assign out_word1    = q.w1;
    assign out_word2    = q.w2;
    assign out_prefixed = q.pfx;
    assign out_invalid  = q.bad;

    // R6
    hold_while_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_word0) && $stable(out_fmt)
                                    && $stable(out_len) && $stable(out_imm));
    // R6
    no_read_presenting_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !mem_rd_en);
    // R5
    pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(pc));
    // R5
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> pc == $past(pc) + AW'($past(out_len)));
    // R7
    trap_one_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_invalid |-> out_len == 2'd1 && out_fmt == 4'd0);
    // R4
    read_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> (mem_addr - pc) < AW'(3));
endmodule

// File: tb/insn_fetch_seq_test.sv
module insn_fetch_seq_test;
    localparam int          CLK_PERIOD = 10;
    localparam int          N   = 24;
    localparam logic [15:0] ORG = 16'h0020;

    localparam logic [15:0] TW0 [N] = '{16'h0002, 16'h0004, 16'h0006, 16'h000C, 16'h0031, 16'h0035,
        16'h0048, 16'h0091, 16'h0205, 16'h0280, 16'h0288, 16'h02B8, 16'h0001, 16'h02B9, 16'h0001,
        16'h0290, 16'h8001, 16'h0001, 16'hFEB8, 16'h02BF, 16'h0003, 16'h023F, 16'h0240, 16'h003F};
    localparam logic [15:0] TW1 [N] = '{16'h0, 16'h0123, 16'h0, 16'h0, 16'h0, 16'h0,
        16'h0, 16'h0, 16'h0010, 16'h0100, 16'h0, 16'h0155, 16'h0, 16'h03AB, 16'h0,
        16'h0, 16'h0, 16'h0, 16'h0, 16'h0012, 16'h0, 16'h0001, 16'h0002, 16'h0};
    localparam logic [15:0] TW2 [N] = '{16'h0, 16'h0234, 16'h0, 16'h0, 16'h0, 16'h0,
        16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h02CD, 16'h0,
        16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0};
    localparam logic [3:0] TFMT [N] = '{4'd0, 4'd2, 4'd1, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8,
        4'd9, 4'd10, 4'd11, 4'd0, 4'd11, 4'd0, 4'd10, 4'd0, 4'd0, 4'd0, 4'd11, 4'd0, 4'd8, 4'd9, 4'd3};
    localparam logic [1:0] TLEN [N] = '{2'd1, 2'd3, 2'd1, 2'd1, 2'd1, 2'd1, 2'd1, 2'd1, 2'd2,
        2'd2, 2'd1, 2'd2, 2'd1, 2'd3, 2'd1, 2'd1, 2'd1, 2'd1, 2'd1, 2'd2, 2'd1, 2'd2, 2'd2, 2'd1};
    localparam logic TPFX [N] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
        1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
    localparam logic TBAD [N] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
        1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
    localparam logic [15:0] TIMM [N] = '{16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0,
        16'h0, 16'h0, 16'h0, 16'h0155, 16'h0, 16'hCDAB, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0,
        16'h0012, 16'h0, 16'h0, 16'h0, 16'h0};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        out_ready = 1'b0;
    logic        mem_rd_en, out_valid, out_prefixed, out_invalid;
    logic [15:0] mem_addr, mem_rdata, pc, out_word0, out_word1, out_word2, out_imm;
    logic [3:0]  out_fmt;
    logic [1:0]  out_len;
    logic [15:0] mem [128];
    int          tests = 0;
    int          fails = 0;
    int          reads = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    insn_fetch_seq #(.AW(16), .DW(16), .RESET_PC(ORG)) uut (
        .clk, .rst_n, .mem_rd_en, .mem_addr, .mem_rdata, .pc, .out_valid, .out_ready,
        .out_fmt, .out_len, .out_word0, .out_word1, .out_word2, .out_imm,
        .out_prefixed, .out_invalid
    );

    always @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= mem[mem_addr[6:0]];
        if (rst_n && mem_rd_en) reads <= reads + 1;
    end

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] exp_pc;
        int          base;
        int          a;
        for (int k = 0; k < 128; k++) mem[k] = 16'h0;
        a = int'(ORG);
        for (int i = 0; i < N; i++) begin
            mem[a] = TW0[i];
            if (TLEN[i] >= 2) mem[a + 1] = TW1[i];
            if (TLEN[i] == 3) mem[a + 2] = TW2[i];
            a = a + int'(TLEN[i]);
        end

        repeat (3) @(negedge clk);
        // R1: state while reset held
        chk("R1", "valid in reset", {31'b0, out_valid}, 0);
        chk("R1", "pc in reset", {16'b0, pc}, {16'b0, ORG});
        rst_n = 1'b1;
        // R1: first read at RESET_PC before the first active edge
        chk("R1", "first read strobe", {31'b0, mem_rd_en}, 1);
        chk("R1", "first read addr", {16'b0, mem_addr}, {16'b0, ORG});
        chk("R1", "prefix after reset", {31'b0, out_prefixed}, 0);

        exp_pc = ORG;
        base = 0;
        for (int i = 0; i < N; i++) begin
            for (int n = 0; n < 40 && !out_valid; n++) @(negedge clk);
            chk("R6", "valid arrives", {31'b0, out_valid}, 1);
            chk("R2", "format", {28'b0, out_fmt}, {28'b0, TFMT[i]});
            chk("R3", "length", {30'b0, out_len}, {30'b0, TLEN[i]});
            chk("R4", "word0", {16'b0, out_word0}, {16'b0, TW0[i]});
            chk("R4", "word1", {16'b0, out_word1}, {16'b0, TW1[i]});
            chk("R4", "word2", {16'b0, out_word2}, {16'b0, TW2[i]});
            chk("R4", "reads per insn", reads - base, {30'b0, TLEN[i]});
            chk("R5", "pc at first word", {16'b0, pc}, {16'b0, exp_pc});
            chk("R7", "invalid flag", {31'b0, out_invalid}, {31'b0, TBAD[i]});
            chk("R8", "prefix flag", {31'b0, out_prefixed}, {31'b0, TPFX[i]});
            chk("R9", "immediate", {16'b0, out_imm}, {16'b0, TIMM[i]});
            if (TFMT[i] == 4'd10)
                chk("R10", "indirect prefix view", {31'b0, out_prefixed}, {31'b0, TPFX[i]});
            if (i == 5 || i == 13) begin
                // R6: stall with ready low
                repeat (3) @(negedge clk);
                chk("R6", "valid held", {31'b0, out_valid}, 1);
                chk("R6", "no read while stalled", {31'b0, mem_rd_en}, 0);
                chk("R6", "word0 held", {16'b0, out_word0}, {16'b0, TW0[i]});
                chk("R6", "imm held", {16'b0, out_imm}, {16'b0, TIMM[i]});
                chk("R5", "pc held", {16'b0, pc}, {16'b0, exp_pc});
            end
            out_ready = 1'b1;
            @(negedge clk);
            out_ready = 1'b0;
            base = reads;
            exp_pc = exp_pc + 16'(TLEN[i]);
            chk("R6", "valid drops after accept", {31'b0, out_valid}, 0);
            chk("R5", "pc advanced", {16'b0, pc}, {16'b0, exp_pc});
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule